// File: doc/BRIEF.md
# Dead-Block Correlating Prefetcher

This block sits beside a first-level data cache and predicts when a cache frame has seen its final touch. Once a frame is predicted dead, it asks for that frame to be replaced early with the block expected to miss there next. Each frame has a running signature in a history table that mirrors the cache tag array. The signature opens with the address that missed into the frame plus the PC of the missing instruction. Every later hit to the frame folds in its PC by truncated addition, and a repeated PC is added again.

A direct-mapped correlation table is indexed by the low signature bits and tagged with the remaining bits. It learns which address missed next in a frame after a given signature, and a 2-bit saturating counter holds the confidence of that pairing. Every access that leaves a frame with an open generation looks up the frame's updated signature. A confident match yields a one-cycle prefetch pulse that names the frame to evict and the address to fetch. A frame gives at most one such pulse per generation. Cache data and the memory side are outside this block.

Top module: `dead_block_prefetcher`

## Requirements
- R1: While `rst` is high and after it falls, `pf_valid` is 0, no frame has an open generation, and every correlation entry is empty, so no prediction appears until the table is trained again.
- R2: A miss sets the frame's 16-bit signature to `acc_addr + acc_pc` modulo 2^16. A hit adds `acc_pc` modulo 2^16, so a hit with PC 0 leaves the signature unchanged and a repeated PC is counted each time.
- R3: A hit to a frame with no open generation (no miss since reset) changes nothing and never predicts.
- R4: A miss to a frame with an open generation trains the correlation entry of the frame's previous signature with `acc_addr`. If the entry is empty or its tag differs, the entry is filled with the new tag and address and a count of 1.
- R5: Training with an address equal to the stored one raises the count by 1, saturating at 3.
- R6: Training with a different address lowers a nonzero count by 1. At count 0, it replaces the stored address and sets the count to 1.
- R7: A prediction needs a valid entry at index `sig[5:0]` whose stored tag equals `sig[15:6]` and whose count is 2 or more.
- R8: After a frame has predicted, it gives no further prediction until its next miss.
- R9: A prediction appears as a single-cycle `pf_valid` pulse with `pf_frame` and `pf_addr`, registered two rising edges after the access is sampled.
- R10: Signatures, generations and the one-shot guard are kept per frame, and a table entry trained through one frame predicts for any frame reaching the same signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A cache access is presented this cycle |
| acc_frame | input | 4 | Cache frame touched by the access |
| acc_miss | input | 1 | 1 when the access missed and filled the frame, 0 for a hit |
| acc_addr | input | 16 | Block address brought in by a miss |
| acc_pc | input | 16 | PC of the accessing instruction |
| pf_valid | output | 1 | Dead-frame prediction pulse |
| pf_frame | output | 4 | Frame to evict early |
| pf_addr | output | 16 | Block address to prefetch into it |

## Verification
The assertions assume the cache reports at most one access per cycle and gives a single frame number per access. They also assume that `acc_frame`, `acc_miss` and `acc_addr` carry meaningful values only while `acc_valid` is high, and their timing properties reach back at most two cycles. The stimulus drives one access every three cycles, always with a frame in range. Each signature it uses is chosen so that a training write and a lookup never land on the same table index in one cycle. Where two signatures share an index, they differ in tag on purpose, to exercise the tag check and the replacement on fill.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  localparam int CONF_W = 2;
  typedef logic [CONF_W-1:0] conf_t;

  localparam conf_t CONF_MAX  = '1;
  localparam conf_t CONF_FILL = conf_t'(1);
  localparam conf_t CONF_PRED = conf_t'(2);

  function automatic conf_t conf_up(input conf_t c);
    return (c == CONF_MAX) ? c : c + conf_t'(1);
  endfunction

  function automatic conf_t conf_down(input conf_t c);
    return (c == '0) ? c : c - conf_t'(1);
  endfunction

endpackage

// File: rtl/dbp_history.sv
module dbp_history #(
  parameter int NUM_FRAMES = 16,
  parameter int ADDR_W     = 16,
  parameter int PC_W       = 16,
  parameter int SIG_W      = 16,
  localparam int FRAME_W   = $clog2(NUM_FRAMES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic [FRAME_W-1:0] acc_frame,
  input  logic               acc_miss,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [PC_W-1:0]    acc_pc,
  input  logic               set_fired,
  output logic               s1_valid,
  output logic [FRAME_W-1:0] s1_frame,
  output logic [SIG_W-1:0]   s1_sig,
  output logic               s1_lookup,
  output logic               s1_train,
  output logic [SIG_W-1:0]   s1_old_sig,
  output logic [ADDR_W-1:0]  s1_addr,
  output logic               s1_fired
);

  // per-frame signature storage, no reset (distributed RAM)
  logic [SIG_W-1:0]      sig_mem [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] gen_open;
  logic [NUM_FRAMES-1:0] fired;

  logic [SIG_W-1:0] old_sig;
  logic             old_open;
  logic [SIG_W-1:0] new_sig;
  logic             upd;

  always_comb begin
    old_sig  = sig_mem[acc_frame];
    old_open = gen_open[acc_frame];
    if (acc_miss) new_sig = SIG_W'(acc_addr) + SIG_W'(acc_pc);
    else          new_sig = old_sig + SIG_W'(acc_pc);
    upd = acc_valid && (acc_miss || old_open);
  end

  always_ff @(posedge clk) begin
    if (upd) sig_mem[acc_frame] <= new_sig;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_open <= '0;
      fired    <= '0;
    end else begin
      if (acc_valid && acc_miss) gen_open[acc_frame] <= 1'b1;
      if (set_fired) fired[s1_frame] <= 1'b1;
      // a newer miss to the same frame opens a fresh generation
      if (acc_valid && acc_miss) fired[acc_frame] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_frame   <= '0;
      s1_sig     <= '0;
      s1_lookup  <= 1'b0;
      s1_train   <= 1'b0;
      s1_old_sig <= '0;
      s1_addr    <= '0;
    end else begin
      s1_valid   <= acc_valid;
      s1_frame   <= acc_frame;
      s1_sig     <= new_sig;
      s1_lookup  <= upd;
      s1_train   <= acc_valid && acc_miss && old_open;
      s1_old_sig <= old_sig;
      s1_addr    <= acc_addr;
    end
  end

  assign s1_fired = fired[s1_frame];

endmodule

// File: rtl/dbp_corr_table.sv
module dbp_corr_table
  import dbp_pkg::*;
#(
  parameter int SIG_W  = 16,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6,
  localparam int ENTRIES = 1 << IDX_W,
  localparam int TAG_W   = SIG_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              train_en,
  input  logic [SIG_W-1:0]  train_sig,
  input  logic [ADDR_W-1:0] train_addr,
  input  logic [SIG_W-1:0]  look_sig,
  output logic              look_hit,
  output logic [ADDR_W-1:0] look_addr
);

  logic [TAG_W-1:0]  tag_mem  [ENTRIES];
  logic [ADDR_W-1:0] addr_mem [ENTRIES];
  conf_t             conf_mem [ENTRIES];
  logic [ENTRIES-1:0] ent_vld;

  logic [IDX_W-1:0] lk_idx, tr_idx;
  logic [TAG_W-1:0] lk_tag, tr_tag;
  logic             tr_present;
  logic             tr_same;
  conf_t            tr_conf;

  always_comb begin
    lk_idx = look_sig[IDX_W-1:0];
    lk_tag = look_sig[SIG_W-1:IDX_W];
    tr_idx = train_sig[IDX_W-1:0];
    tr_tag = train_sig[SIG_W-1:IDX_W];

    look_hit  = ent_vld[lk_idx] && (tag_mem[lk_idx] == lk_tag) &&
                (conf_mem[lk_idx] >= CONF_PRED);
    look_addr = addr_mem[lk_idx];

    tr_present = ent_vld[tr_idx] && (tag_mem[tr_idx] == tr_tag);
    tr_same    = addr_mem[tr_idx] == train_addr;
    tr_conf    = conf_mem[tr_idx];
  end

  always_ff @(posedge clk) begin
    if (train_en) begin
      tag_mem[tr_idx] <= tr_tag;
      if (!tr_present) begin
        addr_mem[tr_idx] <= train_addr;
        conf_mem[tr_idx] <= CONF_FILL;
      end else if (tr_same) begin
        conf_mem[tr_idx] <= conf_up(tr_conf);
      end else if (tr_conf == '0) begin
        addr_mem[tr_idx] <= train_addr;
        conf_mem[tr_idx] <= CONF_FILL;
      end else begin
        conf_mem[tr_idx] <= conf_down(tr_conf);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           ent_vld         <= '0;
    else if (train_en) ent_vld[tr_idx] <= 1'b1;
  end

endmodule

// File: rtl/dead_block_prefetcher.sv
module dead_block_prefetcher #(
  parameter int NUM_FRAMES = 16,
  parameter int ADDR_W     = 16,
  parameter int PC_W       = 16,
  parameter int SIG_W      = 16,
  parameter int CT_IDX_W   = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          acc_valid,
  input  logic [$clog2(NUM_FRAMES)-1:0] acc_frame,
  input  logic                          acc_miss,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic [PC_W-1:0]               acc_pc,
  output logic                          pf_valid,
  output logic [$clog2(NUM_FRAMES)-1:0] pf_frame,
  output logic [ADDR_W-1:0]             pf_addr
);

  localparam int FRAME_W = $clog2(NUM_FRAMES);

  logic               s1_valid, s1_lookup, s1_train, s1_fired;
  logic [FRAME_W-1:0] s1_frame;
  logic [SIG_W-1:0]   s1_sig, s1_old_sig;
  logic [ADDR_W-1:0]  s1_addr;
  logic               ct_hit;
  logic [ADDR_W-1:0]  ct_addr;
  logic               predict;

  dbp_history #(
    .NUM_FRAMES(NUM_FRAMES), .ADDR_W(ADDR_W), .PC_W(PC_W), .SIG_W(SIG_W)
  ) u_hist (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_miss(acc_miss),
    .acc_addr(acc_addr), .acc_pc(acc_pc),
    .set_fired(predict),
    .s1_valid(s1_valid), .s1_frame(s1_frame), .s1_sig(s1_sig),
    .s1_lookup(s1_lookup), .s1_train(s1_train), .s1_old_sig(s1_old_sig),
    .s1_addr(s1_addr), .s1_fired(s1_fired)
  );

  dbp_corr_table #(
    .SIG_W(SIG_W), .ADDR_W(ADDR_W), .IDX_W(CT_IDX_W)
  ) u_ct (
    .clk(clk), .rst(rst),
    .train_en(s1_train), .train_sig(s1_old_sig), .train_addr(s1_addr),
    .look_sig(s1_sig), .look_hit(ct_hit), .look_addr(ct_addr)
  );

  assign predict = s1_valid && s1_lookup && ct_hit && !s1_fired;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
      pf_frame <= '0;
      pf_addr  <= '0;
    end else begin
      pf_valid <= predict;
      if (predict) begin
        pf_frame <= s1_frame;
        pf_addr  <= ct_addr;
      end
    end
  end

endmodule

// File: rtl/dbp_checker.sv
module dbp_checker #(
  parameter int NUM_FRAMES = 16,
  parameter int ADDR_W     = 16,
  localparam int FRAME_W   = $clog2(NUM_FRAMES)
) (
  input logic               clk,
  input logic               rst,
  input logic               acc_valid,
  input logic [FRAME_W-1:0] acc_frame,
  input logic               acc_miss,
  input logic               pf_valid,
  input logic [FRAME_W-1:0] pf_frame,
  input logic [ADDR_W-1:0]  pf_addr
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !pf_valid); // R1

  AST_PF_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> $past(acc_valid, 2)); // R9

  AST_PF_FRAME_MATCH: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> pf_frame == $past(acc_frame, 2)); // R9

  AST_ONE_PER_GEN: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && $past(pf_valid) && pf_frame == $past(pf_frame))
      |-> $past(acc_valid && acc_miss, 2)); // R8

  AST_PF_KNOWN: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> !$isunknown(pf_addr)); // R9

endmodule

bind dead_block_prefetcher dbp_checker #(
  .NUM_FRAMES(NUM_FRAMES), .ADDR_W(ADDR_W)
) u_dbp_checker (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_frame(acc_frame),
  .acc_miss(acc_miss), .pf_valid(pf_valid), .pf_frame(pf_frame),
  .pf_addr(pf_addr)
);

// File: tb/dead_block_prefetcher_bench.sv
module dead_block_prefetcher_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid;
  logic [3:0]  acc_frame;
  logic        acc_miss;
  logic [15:0] acc_addr;
  logic [15:0] acc_pc;
  logic        pf_valid;
  logic [3:0]  pf_frame;
  logic [15:0] pf_addr;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dead_block_prefetcher u_dead_block_prefetcher (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .acc_miss(acc_miss), .acc_addr(acc_addr), .acc_pc(acc_pc),
    .pf_valid(pf_valid), .pf_frame(pf_frame), .pf_addr(pf_addr)
  );

  // fields: miss, frame, addr, pc, exp_valid, exp_frame, exp_addr
  localparam logic [15:0] A  = 16'h1000, B = 16'h2000, C = 16'h3000;
  localparam logic [15:0] P1 = 16'h0004, P2 = 16'h0008, P3 = 16'h0021;
  localparam int NV = 31;
  localparam logic [57:0] VEC [NV] = '{
    {1'b1, 4'd0, A, P1,    1'b0, 4'd0, 16'h0},  // open gen, no train
    {1'b0, 4'd0, A, P2,    1'b0, 4'd0, 16'h0},
    {1'b1, 4'd0, B, P3,    1'b0, 4'd0, 16'h0},  // fill SA->B
    {1'b1, 4'd0, A, P1,    1'b0, 4'd0, 16'h0},  // fill SB->A
    {1'b0, 4'd0, A, P2,    1'b0, 4'd0, 16'h0},  // count 1 too low
    {1'b1, 4'd0, B, P3,    1'b0, 4'd0, 16'h0},  // SA count 2
    {1'b1, 4'd0, A, P1,    1'b0, 4'd0, 16'h0},  // SB count 2
    {1'b0, 4'd0, A, P2,    1'b1, 4'd0, B},      // predict B
    {1'b0, 4'd0, A, 16'h0, 1'b0, 4'd0, 16'h0},  // one per gen
    {1'b1, 4'd0, B, P3,    1'b1, 4'd0, A},      // new gen predicts
    {1'b1, 4'd0, A, P1,    1'b0, 4'd0, 16'h0},  // SB count 3
    {1'b0, 4'd0, A, P2,    1'b1, 4'd0, B},      // SA count 3
    {1'b1, 4'd0, C, P3,    1'b0, 4'd0, 16'h0},  // SA 3->2; tag differs
    {1'b1, 4'd0, A, P1,    1'b0, 4'd0, 16'h0},  // refill idx 0x21
    {1'b0, 4'd0, A, P2,    1'b1, 4'd0, B},      // count 2 still predicts
    {1'b1, 4'd0, C, P3,    1'b0, 4'd0, 16'h0},  // SA 2->1
    {1'b1, 4'd0, A, P1,    1'b0, 4'd0, 16'h0},
    {1'b0, 4'd0, A, P2,    1'b0, 4'd0, 16'h0},  // count 1 silent
    {1'b1, 4'd0, C, P3,    1'b1, 4'd0, A},      // SA 1->0
    {1'b1, 4'd0, A, P1,    1'b0, 4'd0, 16'h0},
    {1'b0, 4'd0, A, P2,    1'b0, 4'd0, 16'h0},  // count 0 silent
    {1'b1, 4'd0, C, P3,    1'b1, 4'd0, A},      // replace SA->C, count 1
    {1'b1, 4'd0, A, P1,    1'b0, 4'd0, 16'h0},
    {1'b0, 4'd0, A, P2,    1'b0, 4'd0, 16'h0},
    {1'b1, 4'd0, C, P3,    1'b1, 4'd0, A},      // SA->C count 2
    {1'b1, 4'd0, A, P1,    1'b0, 4'd0, 16'h0},
    {1'b0, 4'd0, A, P2,    1'b1, 4'd0, C},      // predicts replaced addr
    {1'b1, 4'd0, C, P3,    1'b1, 4'd0, A},
    {1'b1, 4'd2, A, P1,    1'b0, 4'd0, 16'h0},  // frame 2 first miss
    {1'b0, 4'd2, A, P2,    1'b1, 4'd2, C},      // shared table, frame 2
    {1'b0, 4'd2, A, 16'h0, 1'b0, 4'd0, 16'h0}   // frame 2 one-shot
  };

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [57:0] v, input string req);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_miss  = v[57];
    acc_frame = v[56:53];
    acc_addr  = v[52:37];
    acc_pc    = v[36:21];
    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);
    check(req, {15'd0, pf_valid}, {15'd0, v[20]});
    if (v[20]) begin
      check(req, {12'd0, pf_frame}, {12'd0, v[19:16]});
      check(req, pf_addr, v[15:0]);
      @(negedge clk);
      check("R9 pulse", {15'd0, pf_valid}, 16'd0);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; acc_valid = 1'b0; acc_miss = 1'b0;
    acc_frame = '0; acc_addr = '0; acc_pc = '0;
    repeat (3) @(negedge clk);
    check("R1 reset pf_valid", {15'd0, pf_valid}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {15'd0, pf_valid}, 16'd0);

    // R2 R4 R5 R6 R7 R8 R9 R10 through the vector walk
    for (int i = 0; i < NV; i++) access(VEC[i], "R2-R10 vector");

    // R1: reset clears history and table
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset mid-run", {15'd0, pf_valid}, 16'd0);
    rst = 1'b0;

    // retrain SA->B to count 2 through frame 1
    for (int k = 0; k < 2; k++) begin
      access({1'b1, 4'd1, A, P1, 1'b0, 4'd0, 16'h0}, "R1 empty table");
      access({1'b0, 4'd1, A, P2, 1'b0, 4'd0, 16'h0}, "R1 empty table");
      access({1'b1, 4'd1, B, P3, 1'b0, 4'd0, 16'h0}, "R4 fill");
    end
    // frame 2 still stores SA but has no open generation: R3
    access({1'b0, 4'd2, A, 16'h0, 1'b0, 4'd0, 16'h0}, "R3 hit without gen");
    access({1'b0, 4'd7, A, P2, 1'b0, 4'd0, 16'h0}, "R3 hit without gen");
    // R10: frame 3 reaches SA and uses the entry trained by frame 1
    access({1'b1, 4'd3, A, P1, 1'b0, 4'd0, 16'h0}, "R10 open frame 3");
    access({1'b0, 4'd3, A, P2, 1'b1, 4'd3, B}, "R10 shared entry");
    // R2: repeated hit PC 0 keeps the signature, guard blocks repeat (R8)
    access({1'b0, 4'd3, A, 16'h0, 1'b0, 4'd0, 16'h0}, "R8 guard");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule